// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for every incoming frame, whether the frame is meant for this station. It watches the first six bytes of the frame (the destination address) as they arrive one per cycle. It then produces a single accept or reject verdict. Downstream logic uses the verdict to keep or discard the frame.

The checks run in a fixed order:
1. Promiscuous mode accepts everything.
2. Otherwise, an exact compare against the programmed station address is tried, followed by the all-ones broadcast address.
3. Finally, if the multicast hash is enabled, a 64-bin hash table is consulted. The hash bin comes from a CRC-32 that is accumulated byte by byte while the address streams in. The CRC is therefore ready on the same cycle as the last address byte, with no extra pass over the address.

Configuration is a set of static inputs: receive enable, promiscuous, hash enable, the station address as three 16-bit words, and the hash table as four 16-bit words. The verdict appears as a one-cycle valid pulse together with an accept level. The accept level holds until the next frame starts.

Top module: `rx_dest_filter`

## Requirements
- R1: While `cfg_rx_en` is 0, a frame produces no verdict pulse and `verdict_accept` stays 0. Receive enable must be 1 both on the start byte and on the sixth byte.
- R2: With `cfg_promisc` = 1, every frame is accepted whatever its destination address.
- R3: The station address words are compared high byte first:
  - `sta_w0[15:8]` matches destination byte 0 and `sta_w0[7:0]` matches byte 1.
  - `sta_w1` covers bytes 2 and 3.
  - `sta_w2` covers bytes 4 and 5.
  - A full match accepts the frame.
- R4: A destination of FF:FF:FF:FF:FF:FF is accepted even when the hash is disabled or the hash table is all zero.
- R5: The hash bin is bits 31:26 of a CRC-32 taken over the six destination bytes, with these parameters:
  - bytes in arrival order, each byte least significant bit first;
  - reflected polynomial 0xEDB88320;
  - initial value 0xFFFFFFFF;
  - no final inversion.
- R6: Bin bits 5:4 select table word k (`hash_wk`), and bin bits 3:0 select the bit within that word. With `cfg_hash_en` = 1, a frame that matched neither the station nor the broadcast address is accepted exactly when that bit is 1.
- R7: A frame that matches neither the station nor the broadcast address, with hash and promiscuous mode off, is rejected.
- R8: Verdict timing works as follows:
  - `verdict_valid` is high for exactly one cycle, in the cycle after the sixth destination byte is taken.
  - `verdict_accept` holds its value until the next start-of-frame byte.
  - A start-of-frame byte clears `verdict_accept` to 0 in the following cycle.
- R9: After reset, `verdict_valid` and `verdict_accept` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A receive byte is present this cycle |
| byte_sof | input | 1 | The present byte is the first byte of a frame |
| byte_dat | input | 8 | Receive byte |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_hash_en | input | 1 | Enable the multicast hash check |
| sta_w0 | input | 16 | Station address bytes 0 (high) and 1 (low) |
| sta_w1 | input | 16 | Station address bytes 2 (high) and 3 (low) |
| sta_w2 | input | 16 | Station address bytes 4 (high) and 5 (low) |
| hash_w0 | input | 16 | Hash table bins 0..15 |
| hash_w1 | input | 16 | Hash table bins 16..31 |
| hash_w2 | input | 16 | Hash table bins 32..47 |
| hash_w3 | input | 16 | Hash table bins 48..63 |
| verdict_valid | output | 1 | One-cycle pulse: verdict ready |
| verdict_accept | output | 1 | 1 = frame accepted; held until next frame start |

## Verification
Internal state errors show up at the ports as follows:
- A wrong byte counter appears as a verdict pulse one or more cycles early or late, or as no pulse at all. The bench checks the exact cycle after the sixth byte, so such an error is caught on the first frame.
- A corrupted CRC register or a misplaced address byte shows up only in the verdict of that same frame. Directed addresses therefore target each path on its own:
  - byte-swapped station addresses;
  - broadcast with an empty hash table;
  - a hash table holding only the computed bin, and its complement.
- A stale accept level appears at the first byte of the following frame, one cycle after the start byte.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam int WORD_W     = 16;
    localparam int STA_WORDS  = ADDR_BYTES * BYTE_W / WORD_W;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_WORDS = (1 << HASH_IDX_W) / WORD_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic rx_en;
        logic promisc;
        logic hash_en;
    } rdf_cfg_t;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_PROMISC,
        HIT_STATION,
        HIT_BCAST,
        HIT_HASH
    } rdf_hit_e;

    // Reflected CRC update over one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/rdf_crc_acc.sv
module rdf_crc_acc
    import rdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic [BYTE_W-1:0] dat,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] crc_q;

    // A start byte restarts the accumulation from the seed value.
    always_comb crc_next = crc_byte(start ? CRC_INIT : crc_q, dat);

    always_ff @(posedge clk) begin
        if (rst)                crc_q <= CRC_INIT;
        else if (start || step) crc_q <= crc_next;
    end
endmodule

// File: rtl/rdf_addr_capture.sv
module rdf_addr_capture
    import rdf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_start,
    input  logic                      enable,
    input  logic                      byte_take,
    input  logic [BYTE_W-1:0]         dat,
    output logic                      active,
    output logic                      last,
    output logic [N_BYTES*BYTE_W-1:0] addr_next
);
    localparam int CNT_W = $clog2(N_BYTES);

    logic [CNT_W-1:0]          cnt_q;
    logic [N_BYTES*BYTE_W-1:0] addr_q;
    logic                      active_q;
    logic                      first_take;
    logic                      next_take;

    assign first_take = frame_start && enable;
    assign next_take  = byte_take && active_q && !frame_start;
    assign last       = next_take && (cnt_q == CNT_W'(N_BYTES - 1));
    assign active     = active_q;

    // Present the address with the current byte already slotted in.
    for (genvar i = 0; i < N_BYTES; i++) begin : g_slot
        always_comb begin
            if ((first_take && i == 0) || (next_take && cnt_q == CNT_W'(i)))
                addr_next[i*BYTE_W +: BYTE_W] = dat;
            else
                addr_next[i*BYTE_W +: BYTE_W] = addr_q[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
        end else begin
            addr_q <= addr_next;
            if (frame_start) begin
                active_q <= enable;
                cnt_q    <= CNT_W'(1);
            end else if (next_take) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (last) active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rdf_decide.sv
module rdf_decide
    import rdf_pkg::*;
(
    input  rdf_cfg_t                        cfg,
    input  logic [ADDR_BYTES*BYTE_W-1:0]    addr,
    input  logic [CRC_W-1:0]                crc,
    input  logic [STA_WORDS*WORD_W-1:0]     sta,
    input  logic [HASH_WORDS*WORD_W-1:0]    hash_tab,
    output rdf_hit_e                        hit,
    output logic                            accept
);
    logic [STA_WORDS-1:0]  word_eq;
    logic                  sta_eq;
    logic                  bcast;
    logic [HASH_IDX_W-1:0] bin;
    logic                  bin_set;

    // Each word carries two address bytes, the high byte being the earlier one.
    for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
        assign word_eq[w] =
            (sta[w*WORD_W + BYTE_W +: BYTE_W] == addr[(2*w)*BYTE_W +: BYTE_W]) &&
            (sta[w*WORD_W +: BYTE_W]          == addr[(2*w+1)*BYTE_W +: BYTE_W]);
    end

    assign sta_eq  = &word_eq;
    assign bcast   = &addr;
    assign bin     = crc[CRC_W-1 -: HASH_IDX_W];
    // Table is packed word k above word k-1, so the bin is a flat bit index.
    assign bin_set = hash_tab[bin];

    always_comb begin
        if (cfg.promisc)                  hit = HIT_PROMISC;
        else if (sta_eq)                  hit = HIT_STATION;
        else if (bcast)                   hit = HIT_BCAST;
        else if (cfg.hash_en && bin_set)  hit = HIT_HASH;
        else                              hit = HIT_NONE;
    end

    assign accept = (hit != HIT_NONE);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_vld,
    input  logic        byte_sof,
    input  logic [7:0]  byte_dat,
    input  logic        cfg_rx_en,
    input  logic        cfg_promisc,
    input  logic        cfg_hash_en,
    input  logic [15:0] sta_w0,
    input  logic [15:0] sta_w1,
    input  logic [15:0] sta_w2,
    input  logic [15:0] hash_w0,
    input  logic [15:0] hash_w1,
    input  logic [15:0] hash_w2,
    input  logic [15:0] hash_w3,
    output logic        verdict_valid,
    output logic        verdict_accept
);
    rdf_cfg_t                     cfg;
    logic                         frame_start;
    logic                         active;
    logic                         last;
    logic [ADDR_BYTES*BYTE_W-1:0] addr_next;
    logic [CRC_W-1:0]             crc_next;
    rdf_hit_e                     hit;
    logic                         dec_accept;
    logic                         valid_q;
    logic                         accept_q;

    assign cfg         = '{rx_en: cfg_rx_en, promisc: cfg_promisc, hash_en: cfg_hash_en};
    assign frame_start = byte_vld && byte_sof;

    rdf_addr_capture #(.N_BYTES(ADDR_BYTES)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .enable     (cfg.rx_en),
        .byte_take  (byte_vld),
        .dat        (byte_dat),
        .active     (active),
        .last       (last),
        .addr_next  (addr_next)
    );

    rdf_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .start   (frame_start),
        .step    (byte_vld && active),
        .dat     (byte_dat),
        .crc_next(crc_next)
    );

    rdf_decide u_dec (
        .cfg     (cfg),
        .addr    (addr_next),
        .crc     (crc_next),
        .sta     ({sta_w2, sta_w1, sta_w0}),
        .hash_tab({hash_w3, hash_w2, hash_w1, hash_w0}),
        .hit     (hit),
        .accept  (dec_accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            valid_q <= last && cfg.rx_en;
            if (frame_start)             accept_q <= 1'b0;
            else if (last && cfg.rx_en)  accept_q <= dec_accept;
        end
    end

    assign verdict_valid  = valid_q;
    assign verdict_accept = accept_q;
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker (
    input logic clk,
    input logic rst,
    input logic byte_vld,
    input logic byte_sof,
    input logic cfg_rx_en,
    input logic cfg_promisc,
    input logic verdict_valid,
    input logic verdict_accept
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);                               // R8
    AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && byte_sof) |=> (verdict_valid || $stable(verdict_accept))); // R8
    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_sof) |=> !verdict_accept);                     // R8
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !cfg_rx_en |=> !verdict_valid);                                  // R1
    AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (cfg_rx_en && cfg_promisc) |=> (!verdict_valid || verdict_accept)); // R2
endmodule

bind rx_dest_filter rdf_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .byte_vld      (byte_vld),
    .byte_sof      (byte_sof),
    .cfg_rx_en     (cfg_rx_en),
    .cfg_promisc   (cfg_promisc),
    .verdict_valid (verdict_valid),
    .verdict_accept(verdict_accept)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic        byte_sof = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic        cfg_rx_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_hash_en = 1'b0;
    logic [15:0] sta_w0 = 16'h0, sta_w1 = 16'h0, sta_w2 = 16'h0;
    logic [15:0] hash_w0 = 16'h0, hash_w1 = 16'h0, hash_w2 = 16'h0, hash_w3 = 16'h0;
    logic        verdict_valid;
    logic        verdict_accept;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rx_dest_filter u_rx_dest_filter (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_dat(byte_dat), .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc),
        .cfg_hash_en(cfg_hash_en), .sta_w0(sta_w0), .sta_w1(sta_w1),
        .sta_w2(sta_w2), .hash_w0(hash_w0), .hash_w1(hash_w1),
        .hash_w2(hash_w2), .hash_w3(hash_w3),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    always @(negedge clk) if (verdict_valid) pulses++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Address byte i sits at bits [8*i +: 8].
    function automatic logic [47:0] mk(input logic [7:0] a0, a1, a2, a3, a4, a5);
        return {a5, a4, a3, a2, a1, a0};
    endfunction

    function automatic logic [5:0] bin_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 8; b++)
                c = (c[0] ^ a[8*i+b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        return c[31:26];
    endfunction

    task automatic drive(input logic [47:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_sof = (i == 0);
            byte_dat = a[8*i +: 8];
        end
        @(negedge clk);
        byte_vld = 1'b0;
        byte_sof = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input logic exp, input string req);
        drive(a, 6);
        check("R8 pulse after sixth byte", {31'd0, verdict_valid}, 1);
        check(req, {31'd0, verdict_accept}, {31'd0, exp});
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, verdict_valid}, 0);
        check("R8 accept held", {31'd0, verdict_accept}, {31'd0, exp});
    endtask

    task automatic set_hash(input logic [63:0] t);
        {hash_w3, hash_w2, hash_w1, hash_w0} = t;
    endtask

    task automatic t_reset;
        check("R9 reset valid", {31'd0, verdict_valid}, 0);
        check("R9 reset accept", {31'd0, verdict_accept}, 0);
    endtask

    task automatic t_disabled;
        int p0;
        cfg_rx_en = 1'b0; cfg_promisc = 1'b1;
        p0 = pulses;
        drive(mk(8'h12, 8'h34, 8'h56, 8'h78, 8'h9a, 8'hbc), 6);
        repeat (2) @(negedge clk);
        check("R1 no pulse when disabled", pulses, p0);
        check("R1 accept low when disabled", {31'd0, verdict_accept}, 0);
    endtask

    task automatic t_promisc;
        cfg_rx_en = 1'b1; cfg_promisc = 1'b1; cfg_hash_en = 1'b0;
        frame(mk(8'h12, 8'h34, 8'h56, 8'h78, 8'h9a, 8'hbc), 1'b1, "R2 promisc accept");
        cfg_promisc = 1'b0;
    endtask

    task automatic t_station;
        sta_w0 = 16'h0211; sta_w1 = 16'h2233; sta_w2 = 16'h4455;
        frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b1, "R3 station match");
        frame(mk(8'h11, 8'h02, 8'h22, 8'h33, 8'h44, 8'h55), 1'b0, "R3 swapped bytes reject");
        frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h55, 8'h44), 1'b0, "R3 last word swapped reject");
    endtask

    task automatic t_bcast;
        cfg_hash_en = 1'b0; set_hash(64'h0);
        frame(48'hFFFF_FFFF_FFFF, 1'b1, "R4 broadcast hash off");
        cfg_hash_en = 1'b1;
        frame(48'hFFFF_FFFF_FFFF, 1'b1, "R4 broadcast empty table");
    endtask

    task automatic t_hash;
        logic [47:0] a;
        logic [5:0]  b;
        logic [63:0] t;
        cfg_hash_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            a = mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'(k * 37 + 1));
            b = bin_of(a);
            t = 64'h0;
            t[{b[5:4], b[3:0]}] = 1'b1;
            set_hash(t);
            frame(a, 1'b1, "R5 R6 hash bin set");
            set_hash(~t);
            frame(a, 1'b0, "R6 hash bin clear");
        end
        set_hash(64'hFFFF_FFFF_FFFF_FFFF);
        cfg_hash_en = 1'b0;
        frame(mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01), 1'b0, "R7 hash disabled full table");
    endtask

    task automatic t_reject;
        cfg_hash_en = 1'b0; set_hash(64'h0);
        frame(mk(8'hde, 8'had, 8'hbe, 8'hef, 8'h00, 8'h01), 1'b0, "R7 no match reject");
    endtask

    task automatic t_timing;
        cfg_promisc = 1'b1;
        frame(mk(8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 1'b1, "R8 setup accept");
        repeat (3) @(negedge clk);
        check("R8 accept held idle", {31'd0, verdict_accept}, 1);
        drive(mk(8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 1);
        check("R8 sof clears accept", {31'd0, verdict_accept}, 0);
        check("R8 no early pulse", {31'd0, verdict_valid}, 0);
        drive(mk(8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 5);
        check("R8 no pulse on five bytes", {31'd0, verdict_valid}, 0);
        cfg_promisc = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_promisc;
        t_station;
        t_bcast;
        t_hash;
        t_reject;
        t_timing;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule